// File: doc/BRIEF.md
# Interleaved Host-to-Device Address Translator

This block sits inside a memory endpoint and turns a host physical address into a device physical address. Software programs up to four ordered decoders through a narrow register write port. Each decoder holds a host address window (base and size), a skip amount, a granularity code and a ways code, plus a commit flag. A translation request starts a walk over the decoders in index order. The walk keeps a running device base that starts at zero. Each decoder adds its skip to that base. Each decoder that does not claim the address also adds its share of capacity, which is its size divided by its number of ways.

When a committed decoder claims the address, the block takes the offset from that decoder's base. It removes the way-select bits from the offset, adds the running base, and reports the result. A walk that finds no match fails. A walk also fails at once when it reaches a decoder that is uncommitted or that has an unsupported ways code. Either way, the block ends with a single-cycle done pulse that carries the valid flag and the device address.

The state machine has three states. `ST_IDLE` waits for a request. `ST_WALK` examines one decoder per cycle. `ST_DONE` presents the result for one cycle. The transitions are named as follows:
- accept: from `ST_IDLE` to `ST_WALK`, when `req_valid` is high.
- advance: stays in `ST_WALK` and moves to the next decoder, on a miss that is not on the last decoder.
- finish: from `ST_WALK` to `ST_DONE`, on a match, a fault, or a miss on the last decoder.
- release: from `ST_DONE` back to `ST_IDLE`, unconditionally.

Top module: `hdx_xlate`

## Requirements
- R1: Base, size and skip are each written as a low word (select codes 0, 2, 4) and a high word (codes 1, 3, 5). The high word supplies bits 63:32 and bits 31:28 of the low word supply bits 31:28. Bits 27:0 of the low word are ignored and read as zero.
- R2: A write with select code 6 sets the decoder's control word. Granularity g is in bits 3:0, ways code w is in bits 7:4 and commit is in bit 8. Commit set marks only the addressed decoder committed. Commit clear uncommits only that decoder. Select code 7 is ignored.
- R3: A request is accepted on a rising edge with `req_valid` high while idle. The walk starts at decoder 0 with a running base of zero and examines one decoder per edge. If the walk ends on decoder i, `done` is high for the cycle that follows edge i+1 after acceptance.
- R4: Each visited decoder's skip is added to the running base before its range is checked. The skip is therefore included in a match on that same decoder.
- R5: A committed decoder with a valid ways code that does not contain the address adds size >> w to the running base before the walk moves on.
- R6: A decoder contains the address when base <= addr < base + size. For the offset o = addr − base, the result is the running base plus the sum of two parts. The first part is the bits of o below bit 8+g. The second part is (o >> (8+g+w)) << (8+g).
- R7: A visited decoder that is not committed ends the walk at once with the valid flag low. Later decoders are not examined.
- R8: Ways codes 0 to 3 mean 2^w ways. A visited decoder with a ways code above 3 ends the walk at once with the valid flag low.
- R9: If no decoder contains the address, the walk ends after the last decoder with the valid flag low.
- R10: `done` lasts exactly one cycle. `hit` is never high without `done`, and `dpa` is zero whenever `done` is low.
- R11: `req_valid` is ignored while a walk or its done cycle is in progress. One accepted request gives exactly one done pulse, and that pulse carries the accepted address's result.
- R12: After reset every decoder is uncommitted and `done`, `hit` and `dpa` are zero. A request then fails on decoder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Decoder addressed by the write |
| wr_sel | input | 3 | Register select code (R1, R2) |
| wr_data | input | 32 | Write data |
| req_valid | input | 1 | Translation request |
| req_addr | input | 64 | Host physical address |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Translation valid, qualified by done |
| dpa | output | 64 | Device physical address, zero unless done |

## Verification
A corrupted running base or a wrong decoder index shows up as a wrong `dpa` on the done pulse. The error is visible one edge after the claiming decoder is examined. A broken fault path shows up in two ways: as a walk that goes past an uncommitted or badly coded decoder, and as a done pulse that arrives later than the stopping decoder's index implies. The bench therefore checks the latency of every walk as well as its result. A mis-handled commit write flips the outcome of the very next request that reaches that decoder.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

    localparam int REG_W     = 32;
    localparam int ADDR_W    = 2 * REG_W;
    localparam int CODE_W    = 4;
    localparam int COMMIT_B  = 8;
    localparam int MIN_SHIFT = 8;
    localparam int MAX_WAYS  = 3;

    typedef enum logic [2:0] {
        SEL_BASE_LO = 3'd0,
        SEL_BASE_HI = 3'd1,
        SEL_SIZE_LO = 3'd2,
        SEL_SIZE_HI = 3'd3,
        SEL_SKIP_LO = 3'd4,
        SEL_SKIP_HI = 3'd5,
        SEL_CTRL    = 3'd6,
        SEL_NONE    = 3'd7
    } wr_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] size;
        logic [ADDR_W-1:0] skip;
        logic [CODE_W-1:0] gran;
        logic [CODE_W-1:0] ways;
    } dec_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WALK = 2'd1,
        ST_DONE = 2'd2
    } walk_st_e;

endpackage

// File: rtl/hdx_regs.sv
module hdx_regs
    import hdx_pkg::*;
#(
    parameter int NUM_DEC  = 4,
    parameter int KEEP_LSB = 28,
    parameter int IDX_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [2:0]           wr_sel,
    input  logic [REG_W-1:0]     wr_data,
    output dec_cfg_t             cfg_o [NUM_DEC],
    output logic [NUM_DEC-1:0]   committed_o
);

    localparam int KEPT_W = ADDR_W - KEEP_LSB;

    for (genvar d = 0; d < NUM_DEC; d++) begin : g_dec
        logic [KEPT_W-1:0] base_q;
        logic [KEPT_W-1:0] size_q;
        logic [KEPT_W-1:0] skip_q;
        logic [CODE_W-1:0] gran_q;
        logic [CODE_W-1:0] ways_q;
        logic              commit_q;
        logic              sel_me;

        assign sel_me = wr_en && (wr_idx == IDX_W'(d));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q   <= '0;
                size_q   <= '0;
                skip_q   <= '0;
                gran_q   <= '0;
                ways_q   <= '0;
                commit_q <= 1'b0;
            end else if (sel_me) begin
                unique case (wr_sel_e'(wr_sel))
                    SEL_BASE_LO: base_q[REG_W-KEEP_LSB-1:0] <= wr_data[REG_W-1:KEEP_LSB];
                    SEL_BASE_HI: base_q[KEPT_W-1:REG_W-KEEP_LSB] <= wr_data;
                    SEL_SIZE_LO: size_q[REG_W-KEEP_LSB-1:0] <= wr_data[REG_W-1:KEEP_LSB];
                    SEL_SIZE_HI: size_q[KEPT_W-1:REG_W-KEEP_LSB] <= wr_data;
                    SEL_SKIP_LO: skip_q[REG_W-KEEP_LSB-1:0] <= wr_data[REG_W-1:KEEP_LSB];
                    SEL_SKIP_HI: skip_q[KEPT_W-1:REG_W-KEEP_LSB] <= wr_data;
                    SEL_CTRL: begin
                        gran_q   <= wr_data[CODE_W-1:0];
                        ways_q   <= wr_data[2*CODE_W-1:CODE_W];
                        commit_q <= wr_data[COMMIT_B];
                    end
                    default: ;
                endcase
            end
        end

        assign cfg_o[d].base = {base_q, {KEEP_LSB{1'b0}}};
        assign cfg_o[d].size = {size_q, {KEEP_LSB{1'b0}}};
        assign cfg_o[d].skip = {skip_q, {KEEP_LSB{1'b0}}};
        assign cfg_o[d].gran = gran_q;
        assign cfg_o[d].ways = ways_q;
        assign committed_o[d] = commit_q;
    end

endmodule

// File: rtl/hdx_step.sv
module hdx_step
    import hdx_pkg::*;
(
    input  dec_cfg_t          cfg_i,
    input  logic              commit_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] run_base_i,
    output logic              fault_o,
    output logic              match_o,
    output logic [ADDR_W-1:0] next_base_o,
    output logic [ADDR_W-1:0] dpa_o
);

    localparam int SH_W = 7;

    logic [ADDR_W-1:0] acc;
    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] lo_mask;
    logic [ADDR_W-1:0] squeezed;
    logic [SH_W-1:0]   sh_lo;
    logic [SH_W-1:0]   sh_hi;
    logic [1:0]        way_sh;
    logic              bad_ways;
    logic              in_range;

    always_comb begin
        acc      = run_base_i + cfg_i.skip;
        off      = addr_i - cfg_i.base;
        bad_ways = cfg_i.ways > CODE_W'(MAX_WAYS);
        way_sh   = cfg_i.ways[1:0];
        in_range = (addr_i >= cfg_i.base) && (off < cfg_i.size);
        fault_o  = !commit_i || bad_ways;
        match_o  = !fault_o && in_range;

        sh_lo    = SH_W'(MIN_SHIFT) + SH_W'(cfg_i.gran);
        sh_hi    = sh_lo + SH_W'(way_sh);
        lo_mask  = ~({ADDR_W{1'b1}} << sh_lo);
        squeezed = (off & lo_mask) | ((off >> sh_hi) << sh_lo);

        dpa_o       = acc + squeezed;
        next_base_o = acc + (cfg_i.size >> way_sh);
    end

endmodule

// File: rtl/hdx_walk.sv
module hdx_walk
    import hdx_pkg::*;
#(
    parameter int NUM_DEC = 4,
    parameter int IDX_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  dec_cfg_t          cfg_i [NUM_DEC],
    input  logic [NUM_DEC-1:0] committed_i,
    output logic              done_o,
    output logic              hit_o,
    output logic [ADDR_W-1:0] dpa_o,
    output logic              busy_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DEC - 1);

    walk_st_e          st_q, st_d;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  idx_q;
    logic              res_hit_q;
    logic [ADDR_W-1:0] res_dpa_q;

    logic              step_fault;
    logic              step_match;
    logic [ADDR_W-1:0] step_next;
    logic [ADDR_W-1:0] step_dpa;
    logic              at_last;

    hdx_step u_step (
        .cfg_i       (cfg_i[idx_q]),
        .commit_i    (committed_i[idx_q]),
        .addr_i      (addr_q),
        .run_base_i  (base_q),
        .fault_o     (step_fault),
        .match_o     (step_match),
        .next_base_o (step_next),
        .dpa_o       (step_dpa)
    );

    assign at_last = (idx_q == LAST_IDX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // transitions: accept, advance, finish, release
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (req_valid) st_d = ST_WALK;
            ST_WALK: if (step_fault || step_match || at_last) st_d = ST_DONE;
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            base_q    <= '0;
            idx_q     <= '0;
            res_hit_q <= 1'b0;
            res_dpa_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q    <= req_addr;
                        base_q    <= '0;
                        idx_q     <= '0;
                        res_hit_q <= 1'b0;
                        res_dpa_q <= '0;
                    end
                end
                ST_WALK: begin
                    if (step_fault) begin
                        res_hit_q <= 1'b0;
                    end else if (step_match) begin
                        res_hit_q <= 1'b1;
                        res_dpa_q <= step_dpa;
                    end else begin
                        base_q <= step_next;
                        if (!at_last) idx_q <= idx_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        done_o = (st_q == ST_DONE);
        hit_o  = done_o && res_hit_q;
        dpa_o  = done_o ? res_dpa_q : '0;
        busy_o = (st_q != ST_IDLE);
    end

endmodule

// File: rtl/hdx_xlate.sv
module hdx_xlate
    import hdx_pkg::*;
#(
    parameter int NUM_DEC  = 4,
    parameter int KEEP_LSB = 28,
    localparam int IDX_W   = (NUM_DEC > 1) ? $clog2(NUM_DEC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [2:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              req_valid,
    input  logic [63:0]       req_addr,
    output logic              done,
    output logic              hit,
    output logic [63:0]       dpa
);

    dec_cfg_t           dec_cfg [NUM_DEC];
    logic [NUM_DEC-1:0] dec_committed;
    logic               walk_busy;

    hdx_regs #(
        .NUM_DEC  (NUM_DEC),
        .KEEP_LSB (KEEP_LSB),
        .IDX_W    (IDX_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .cfg_o       (dec_cfg),
        .committed_o (dec_committed)
    );

    hdx_walk #(
        .NUM_DEC (NUM_DEC),
        .IDX_W   (IDX_W)
    ) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .cfg_i       (dec_cfg),
        .committed_i (dec_committed),
        .done_o      (done),
        .hit_o       (hit),
        .dpa_o       (dpa),
        .busy_o      (walk_busy)
    );

endmodule

// File: rtl/hdx_xlate_chk.sv
module hdx_xlate_chk #(
    parameter int NUM_DEC = 4,
    parameter int IDX_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [IDX_W-1:0]   wr_idx,
    input logic [2:0]         wr_sel,
    input logic               wr_commit,
    input logic               req_valid,
    input logic               done,
    input logic               hit,
    input logic [63:0]        dpa,
    input logic               busy,
    input logic [NUM_DEC-1:0] committed
);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    hit_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> done);

    // R10
    dpa_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (dpa == 64'd0));

    // R2
    commit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd6 && wr_commit) |=> committed[$past(wr_idx)]);

    // R2
    commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd6 && !wr_commit) |=> !committed[$past(wr_idx)]);

    // R11
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> (busy && !done));

    // R3
    done_after_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

endmodule

bind hdx_xlate hdx_xlate_chk #(
    .NUM_DEC (NUM_DEC),
    .IDX_W   (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_sel    (wr_sel),
    .wr_commit (wr_data[8]),
    .req_valid (req_valid),
    .done      (done),
    .hit       (hit),
    .dpa       (dpa),
    .busy      (walk_busy),
    .committed (dec_committed)
);

// File: tb/hdx_xlate_tb.sv
module hdx_xlate_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NDEC       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_idx = '0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic        req_valid = 1'b0;
    logic [63:0] req_addr = '0;
    logic        done;
    logic        hit;
    logic [63:0] dpa;

    int checks = 0;
    int errors = 0;

    logic [63:0] m_base [NDEC];
    logic [63:0] m_size [NDEC];
    logic [63:0] m_skip [NDEC];
    logic [3:0]  m_gran [NDEC];
    logic [3:0]  m_ways [NDEC];
    bit          m_com  [NDEC];

    always #(CLK_PERIOD/2) clk = ~clk;

    hdx_xlate u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .done      (done),
        .hit       (hit),
        .dpa       (dpa)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected walk built from R3-R9
    function automatic void model(input logic [63:0] a, output bit h,
                                  output logic [63:0] d, output int last);
        logic [63:0] run = '0;
        h = 0; d = '0; last = NDEC - 1;
        for (int i = 0; i < NDEC; i++) begin
            run = run + m_skip[i];
            if (!m_com[i] || m_ways[i] > 4'd3) begin
                last = i;
                return;
            end
            if (a >= m_base[i] && (a - m_base[i]) < m_size[i]) begin
                logic [63:0] o;
                int lo, hi;
                o  = a - m_base[i];
                lo = 8 + int'(m_gran[i]);
                hi = lo + int'(m_ways[i]);
                d  = run + ((o & ((64'd1 << lo) - 64'd1)) | ((o >> hi) << lo));
                h  = 1;
                last = i;
                return;
            end
            run = run + (m_size[i] >> m_ways[i]);
        end
    endfunction

    task automatic wr(int i, logic [2:0] sel, logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 2'(i); wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_ctrl(int i, logic [3:0] g, logic [3:0] w, bit c);
        wr(i, 3'd6, {23'd0, c, w, g});
        m_gran[i] = g; m_ways[i] = w; m_com[i] = c;
    endtask

    // low words carry junk in bits 27:0 that R1 says are dropped
    task automatic set_dec(int i, logic [63:0] b, logic [63:0] s, logic [63:0] k,
                           logic [3:0] g, logic [3:0] w);
        wr(i, 3'd0, b[31:0] | 32'h05A5_A5A5);
        wr(i, 3'd1, b[63:32]);
        wr(i, 3'd2, s[31:0] | 32'h0123_4567);
        wr(i, 3'd3, s[63:32]);
        wr(i, 3'd4, k[31:0] | 32'h0FED_CBA9);
        wr(i, 3'd5, k[63:32]);
        m_base[i] = b & ~64'h0FFF_FFFF;
        m_size[i] = s & ~64'h0FFF_FFFF;
        m_skip[i] = k & ~64'h0FFF_FFFF;
        set_ctrl(i, g, w, 1'b1);
    endtask

    task automatic run_req(string tag, logic [63:0] a);
        bit eh; logic [63:0] ed; int el; int n;
        model(a, eh, ed, el);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 12) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " R3 latency"}, 64'(n), 64'(el + 1));
        chk({tag, " hit"}, 64'(hit), 64'(eh));
        chk({tag, " dpa"}, dpa, ed);
        @(negedge clk);
        chk({tag, " R10 single pulse"}, 64'(done), 64'd0);
    endtask

    task automatic t_reset();
        chk("R12 done", 64'(done), 64'd0);
        chk("R12 hit", 64'(hit), 64'd0);
        chk("R12 dpa", dpa, 64'd0);
        for (int i = 0; i < NDEC; i++) begin
            m_base[i] = '0; m_size[i] = '0; m_skip[i] = '0;
            m_gran[i] = '0; m_ways[i] = '0; m_com[i] = 0;
        end
        run_req("R12 uncommitted at reset", 64'h1_0000_0000);
    endtask

    task automatic t_program();
        set_dec(0, 64'h1_0000_0000, 64'h1000_0000, 64'h3000_0000, 4'd0, 4'd0);
        set_dec(1, 64'h2_0000_0000, 64'h4000_0000, 64'h1000_0000, 4'd2, 4'd1);
        set_dec(2, 64'h3_0000_0000, 64'h8000_0000, 64'h0,         4'd1, 4'd2);
        set_dec(3, 64'h4_0000_0000, 64'h1000_0000, 64'h2000_0000, 4'd0, 4'd3);
        // R2 select code 7 ignored: junk write to decoder 0 changes nothing
        wr(0, 3'd7, 32'hFFFF_FFFF);
    endtask

    task automatic t_hits();
        run_req("R1 R4 dec0 at base", 64'h1_0000_0000);
        run_req("R6 dec0 w0", 64'h1_0ABC_DE12);
        run_req("R6 R5 dec1 w1", 64'h2_1234_5678);
        run_req("R5 dec2 w2", 64'h3_7654_3217);
        run_req("R5 dec3 w3", 64'h4_0FFF_FFF0);
    endtask

    task automatic t_misses();
        run_req("R9 below all", 64'h0_FFFF_FFFF);
        run_req("R9 dec0 end exclusive", 64'h1_1000_0000);
        run_req("R9 above all", 64'h9_0000_0000);
    endtask

    task automatic t_uncommit();
        set_ctrl(1, 4'd2, 4'd1, 1'b0);
        run_req("R7 dec1 uncommitted stops walk", 64'h3_0000_0100);
        run_req("R2 dec0 still committed", 64'h1_0000_0040);
        set_ctrl(1, 4'd2, 4'd1, 1'b1);
        run_req("R2 recommit dec1", 64'h3_0000_0100);
    endtask

    task automatic t_bad_ways();
        set_ctrl(3, 4'd0, 4'd5, 1'b1);
        run_req("R8 ways code 5", 64'h4_0000_0200);
        run_req("R8 dec0 unaffected", 64'h1_0000_0080);
        set_ctrl(3, 4'd0, 4'd3, 1'b1);
    endtask

    task automatic t_busy_ignore();
        bit eh; logic [63:0] ed; int el; int pulses;
        model(64'h4_0000_1234, eh, ed, el);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 64'h4_0000_1234;
        @(negedge clk);
        req_addr = 64'h1_0000_0000;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        pulses = 0;
        for (int c = 0; c < 10; c++) begin
            if (done) begin
                pulses++;
                chk("R11 first request result", dpa, ed);
            end
            @(negedge clk);
        end
        chk("R11 one pulse", 64'(pulses), 64'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_hits();
        t_misses();
        t_uncommit();
        t_bad_ways();
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule